// File: doc/BRIEF.md
# Decode-Stage Stall Controller for a Forwarding Five-Stage Pipeline

This block decides, every cycle, whether the instruction sitting in decode can move on to execute in a five-stage integer pipeline that already forwards results and compares branch operands in decode. Forwarding covers most dependencies. The remaining cases need a stall: a loaded value that is not yet available, a branch that needs an operand still being computed, and a branch that reads a load result still in the memory stage.

The block holds the decode and execute instruction registers and the memory-stage destination tag. On a stall it freezes decode, drops the program-counter enable so that fetch presents the same word again, and loads a bubble (all-zero word, destination zero) into execute. The register file, ALU, forwarding multiplexers and memories sit outside it. Fetch supplies one instruction word per cycle and must re-present the same word whenever `pc_enable` was low.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: Fields: opcode is bits 31:26, first source bits 25:21, second source bits 20:16. Opcodes: register-register 000000, load 100011, add-immediate 001100, branch-equal 000100, jump 000010, store 101011. The destination is bits 15:11 for register-register, bits 20:16 for load and add-immediate, and zero for every other opcode.
- R2: Load-use: stall when execute holds a load with a nonzero destination that matches either decode source, unless the decode opcode is load, add-immediate or jump. This includes a store that reads the loaded register as data.
- R3: Load-address: stall when execute holds a load with a nonzero destination, decode holds a load or add-immediate, and the first source matches. A match on the second source alone does not stall.
- R4: Branch after load in memory: stall when decode holds branch-equal and the memory stage holds a load whose nonzero destination matches either branch source.
- R5: Branch after write: stall when decode holds branch-equal and the nonzero execute destination matches either branch source.
- R6: A zero destination never causes a stall. This covers register 0, and branch-equal, jump and store, which carry zero.
- R7: While `stall` is high, `pc_enable` is low and `id_instr` keeps its value at the next edge. `ex_instr` and `ex_dest` become zero at that edge.
- R8: Without a stall, `id_instr` takes `fetch_instr`. `ex_instr` takes the old `id_instr`, and `ex_dest` takes its destination as decoded per R1.
- R9: At every edge out of reset, `mem_dest` takes `ex_dest`, and `mem_is_load` is set when `ex_instr` held a load.
- R10: Synchronous active-high reset clears all stage registers to the all-zero bubble; `stall` is low after reset.
- R11: A load followed at once by a dependent branch stalls two cycles. A load followed by a dependent ALU op or store, or an ALU op followed by a dependent branch, stalls one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr | input | 32 | Instruction word from fetch, held by fetch while `pc_enable` is low |
| stall | output | 1 | Hazard detected this cycle |
| pc_enable | output | 1 | Program counter may advance |
| id_instr | output | 32 | Decode-stage instruction register |
| ex_instr | output | 32 | Execute-stage instruction register |
| ex_dest | output | 5 | Destination tag carried in execute |
| mem_dest | output | 5 | Destination tag carried in memory stage |
| mem_is_load | output | 1 | Memory stage holds a load |

## Verification
The branch-after-load rule is the hardest to reach on its own. It needs a load two slots ahead of a branch, with no stall between them that would reshape the stage contents. The stimulus places an unrelated instruction between the load and the branch, so that only the memory-stage comparison can fire. It also runs the back-to-back load and branch pair, where the execute rules and then the memory rule fire in successive cycles. A behavioural model in the bench replays the program with its own fetch pointer, and each short program is also checked for its total stall count.

// File: rtl/stall_pkg.sv
package stall_pkg;

    localparam int XLEN   = 32;
    localparam int OP_W   = 6;
    localparam int RIDX_W = 5;
    localparam int OP_LSB = XLEN - OP_W;
    localparam int S1_LSB = OP_LSB - RIDX_W;
    localparam int S2_LSB = S1_LSB - RIDX_W;
    localparam int RD_LSB = S2_LSB - RIDX_W;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [OP_W-1:0]   opcode_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    localparam opcode_t OPC_RR   = 6'b000000;
    localparam opcode_t OPC_LW   = 6'b100011;
    localparam opcode_t OPC_ADDI = 6'b001100;
    localparam opcode_t OPC_BEQ  = 6'b000100;
    localparam opcode_t OPC_J    = 6'b000010;
    localparam opcode_t OPC_SW   = 6'b101011;

    localparam word_t BUBBLE = '0;

    typedef struct packed {
        opcode_t op;
        ridx_t   src1;
        ridx_t   src2;
        ridx_t   dst;
    } dec_fields_t;

    typedef struct packed {
        word_t ir;
        ridx_t dst;
    } ex_slot_t;

    typedef struct packed {
        logic  is_load;
        ridx_t dst;
    } mem_slot_t;

    function automatic dec_fields_t split_fields(word_t ir);
        dec_fields_t f;
        f.op   = ir[OP_LSB +: OP_W];
        f.src1 = ir[S1_LSB +: RIDX_W];
        f.src2 = ir[S2_LSB +: RIDX_W];
        unique case (f.op)
            OPC_RR:          f.dst = ir[RD_LSB +: RIDX_W];
            OPC_LW, OPC_ADDI: f.dst = ir[S2_LSB +: RIDX_W];
            default:         f.dst = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/instr_field_decode.sv
module instr_field_decode
    import stall_pkg::*;
(
    input  word_t       ir,
    output dec_fields_t fields
);
    always_comb fields = split_fields(ir);
endmodule

// File: rtl/stall_rules.sv
module stall_rules
    import stall_pkg::*;
(
    input  dec_fields_t id_f,
    input  opcode_t     ex_op,
    input  ridx_t       ex_dst,
    input  mem_slot_t   mem_s,
    output logic [3:0]  rule_hits,
    output logic        stall
);
    logic id_is_beq, id_addr_form, id_excl, ex_live_load;
    logic hit_ex_any, hit_ex_s1, hit_mem_any;

    always_comb begin
        id_is_beq    = (id_f.op == OPC_BEQ);
        id_addr_form = (id_f.op == OPC_LW) || (id_f.op == OPC_ADDI);
        id_excl      = id_addr_form || (id_f.op == OPC_J);
        ex_live_load = (ex_op == OPC_LW) && (ex_dst != '0);
        hit_ex_s1    = (id_f.src1 == ex_dst);
        hit_ex_any   = hit_ex_s1 || (id_f.src2 == ex_dst);
        hit_mem_any  = (mem_s.dst != '0) &&
                       ((id_f.src1 == mem_s.dst) || (id_f.src2 == mem_s.dst));

        rule_hits[0] = ex_live_load && !id_excl && hit_ex_any;
        rule_hits[1] = ex_live_load && id_addr_form && hit_ex_s1;
        rule_hits[2] = id_is_beq && mem_s.is_load && hit_mem_any;
        rule_hits[3] = id_is_beq && (ex_dst != '0) && hit_ex_any;
        stall        = |rule_hits;
    end
endmodule

// File: rtl/pipe_stage_regs.sv
module pipe_stage_regs
    import stall_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold,
    input  word_t     fetch_word,
    input  ridx_t     id_dst,
    output word_t     id_ir,
    output ex_slot_t  ex_s,
    output mem_slot_t mem_s
);
    always_ff @(posedge clk) begin
        if (rst) begin
            id_ir <= BUBBLE;
            ex_s  <= '{ir: BUBBLE, dst: '0};
            mem_s <= '{is_load: 1'b0, dst: '0};
        end else begin
            mem_s.is_load <= (ex_s.ir[OP_LSB +: OP_W] == OPC_LW);
            mem_s.dst     <= ex_s.dst;
            if (hold) begin
                ex_s <= '{ir: BUBBLE, dst: '0};
            end else begin
                ex_s  <= '{ir: id_ir, dst: id_dst};
                id_ir <= fetch_word;
            end
        end
    end

    assert_decode_hold_R7: assert property (@(posedge clk) disable iff (rst)
        hold |=> id_ir == $past(id_ir));
    assert_bubble_insert_R7: assert property (@(posedge clk) disable iff (rst)
        hold |=> (ex_s.ir == BUBBLE) && (ex_s.dst == '0));
    assert_advance_R8: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (ex_s.ir == $past(id_ir)) && (id_ir == $past(fetch_word)));
    assert_mem_follow_R9: assert property (@(posedge clk) disable iff (rst)
        !hold || hold |=> mem_s.dst == $past(ex_s.dst));
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (id_ir == BUBBLE) && (ex_s.ir == BUBBLE) && (mem_s.dst == '0));
endmodule

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl
    import stall_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_instr,
    output logic        stall,
    output logic        pc_enable,
    output logic [31:0] id_instr,
    output logic [31:0] ex_instr,
    output logic [4:0]  ex_dest,
    output logic [4:0]  mem_dest,
    output logic        mem_is_load
);
    dec_fields_t id_f;
    ex_slot_t    ex_s;
    mem_slot_t   mem_s;
    word_t       id_ir;
    logic [3:0]  rule_hits;
    logic        stall_w;

    instr_field_decode u_id_dec (
        .ir     (id_ir),
        .fields (id_f)
    );

    stall_rules u_rules (
        .id_f      (id_f),
        .ex_op     (ex_s.ir[OP_LSB +: OP_W]),
        .ex_dst    (ex_s.dst),
        .mem_s     (mem_s),
        .rule_hits (rule_hits),
        .stall     (stall_w)
    );

    pipe_stage_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .hold       (stall_w),
        .fetch_word (fetch_instr),
        .id_dst     (id_f.dst),
        .id_ir      (id_ir),
        .ex_s       (ex_s),
        .mem_s      (mem_s)
    );

    always_comb begin
        stall       = stall_w;
        pc_enable   = !stall_w;
        id_instr    = id_ir;
        ex_instr    = ex_s.ir;
        ex_dest     = ex_s.dst;
        mem_dest    = mem_s.dst;
        mem_is_load = mem_s.is_load;
    end

    assert_zero_dest_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        stall |-> (ex_dest != '0) || (mem_dest != '0));
    assert_load_branch_twice_R11: assert property (@(posedge clk) disable iff (rst)
        rule_hits[3] && (ex_instr[31:26] == OPC_LW) |=> stall && rule_hits[2]);
    assert_branch_only_rules_R4: assert property (@(posedge clk) disable iff (rst)
        (rule_hits[2] || rule_hits[3]) |-> id_instr[31:26] == OPC_BEQ);
    assert_addr_rule_first_src_R3: assert property (@(posedge clk) disable iff (rst)
        rule_hits[1] |-> (id_instr[25:21] == ex_dest) && (ex_instr[31:26] == OPC_LW));
endmodule

// File: tb/pipe_stall_ctrl_tb.sv
module pipe_stall_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] M_LW = 6'b100011, M_ADDI = 6'b001100, M_BEQ = 6'b000100,
                           M_J = 6'b000010, M_SW = 6'b101011, M_RR = 6'b000000;

    logic clk = 1'b0;
    logic rst;
    logic [31:0] fetch_instr;
    logic stall, pc_enable, mem_is_load;
    logic [31:0] id_instr, ex_instr;
    logic [4:0] ex_dest, mem_dest;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_id, m_ex;
    logic [4:0]  m_exd, m_memd;
    logic        m_memload;

    pipe_stall_ctrl u_dut (
        .clk(clk), .rst(rst), .fetch_instr(fetch_instr), .stall(stall),
        .pc_enable(pc_enable), .id_instr(id_instr), .ex_instr(ex_instr),
        .ex_dest(ex_dest), .mem_dest(mem_dest), .mem_is_load(mem_is_load)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rr(input int rd, input int rs, input int rt);
        return {M_RR, 5'(rs), 5'(rt), 5'(rd), 11'd0};
    endfunction
    function automatic logic [31:0] ld(input int rt, input int rs);
        return {M_LW, 5'(rs), 5'(rt), 16'h0040};
    endfunction
    function automatic logic [31:0] addi(input int rt, input int rs);
        return {M_ADDI, 5'(rs), 5'(rt), 16'h0004};
    endfunction
    function automatic logic [31:0] beq(input int rs, input int rt);
        return {M_BEQ, 5'(rs), 5'(rt), 16'hFFE7};
    endfunction
    function automatic logic [31:0] st(input int rt, input int rs);
        return {M_SW, 5'(rs), 5'(rt), 16'h0008};
    endfunction
    function automatic logic [31:0] jmp(input logic [25:0] tgt);
        return {M_J, tgt};
    endfunction

    // destination per R1, written as a lookup on opcode
    function automatic logic [4:0] model_dest(input logic [31:0] w);
        if (w[31:26] == M_RR) return w[15:11];
        if (w[31:26] == M_LW || w[31:26] == M_ADDI) return w[20:16];
        return 5'd0;
    endfunction

    // returns which rule predicts a stall (2,3,4,5) or 0
    function automatic int model_reason();
        logic [5:0] op = m_id[31:26];
        logic [4:0] a = m_id[25:21];
        logic [4:0] b = m_id[20:16];
        bit ex_ld = (m_ex[31:26] == M_LW);
        int r = 0;
        if (m_exd != 0) begin
            if (ex_ld && op != M_LW && op != M_ADDI && op != M_J && (a == m_exd || b == m_exd)) r = 2;
            else if (ex_ld && (op == M_LW || op == M_ADDI) && a == m_exd) r = 3;
            else if (op == M_BEQ && (a == m_exd || b == m_exd)) r = 5;
        end
        if (r == 0 && op == M_BEQ && m_memload && m_memd != 0 && (a == m_memd || b == m_memd)) r = 4;
        return r;
    endfunction

    task automatic run_seg(input logic [31:0] seg[$], input int exp_stalls, input string tag);
        logic [31:0] prog[$];
        int pc = 0;
        int nstall = 0;
        prog = seg;
        for (int k = 0; k < 4; k++) prog.push_back(32'h0);
        while (pc < prog.size()) begin
            int why;
            string st_tag;
            @(negedge clk);
            fetch_instr = prog[pc];
            #1;
            why = model_reason();
            case (why)
                2: st_tag = "R2 load-use stall";
                3: st_tag = "R3 load-address stall";
                4: st_tag = "R4 branch after load stall";
                5: st_tag = "R5 branch after write stall";
                default: st_tag = "R6 no stall expected";
            endcase
            check(stall == (why != 0), st_tag, 32'(stall), 32'(why != 0));
            check(pc_enable == (why == 0), "R7 pc_enable", 32'(pc_enable), 32'(why == 0));
            check(id_instr == m_id, "R7 R8 id_instr", id_instr, m_id);
            check(ex_instr == m_ex, "R7 R8 ex_instr", ex_instr, m_ex);
            check(ex_dest == m_exd, "R1 R8 ex_dest", 32'(ex_dest), 32'(m_exd));
            check(mem_dest == m_memd, "R9 mem_dest", 32'(mem_dest), 32'(m_memd));
            check(mem_is_load == m_memload, "R9 mem_is_load", 32'(mem_is_load), 32'(m_memload));
            if (stall) nstall++;
            // advance model to the next edge
            m_memload = (m_ex[31:26] == M_LW);
            m_memd    = m_exd;
            if (why != 0) begin
                m_ex  = 32'h0;
                m_exd = 5'd0;
            end else begin
                m_ex  = m_id;
                m_exd = model_dest(m_id);
                m_id  = prog[pc];
                pc++;
            end
        end
        check(nstall == exp_stalls, tag, 32'(nstall), 32'(exp_stalls));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] s[$];
        rst = 1'b1;
        fetch_instr = 32'h0;
        m_id = 0; m_ex = 0; m_exd = 0; m_memd = 0; m_memload = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        check(stall == 1'b0, "R10 stall after reset", 32'(stall), 0);
        check(id_instr == 0 && ex_instr == 0, "R10 stage words cleared", id_instr | ex_instr, 0);
        check(ex_dest == 0 && mem_dest == 0 && !mem_is_load, "R10 tags cleared",
              32'({ex_dest, mem_dest, mem_is_load}), 0);

        s = '{ld(1,0), ld(2,0), rr(3,1,2), rr(4,3,1), beq(3,4), rr(4,4,4)};
        run_seg(s, 2, "R11 mixed sequence total stalls");
        s = '{ld(5,1), beq(5,4)};
        run_seg(s, 2, "R11 load then branch two stalls");
        s = '{ld(6,0), ld(7,6)};
        run_seg(s, 1, "R3 load base from load");
        s = '{ld(6,0), addi(8,6)};
        run_seg(s, 1, "R3 addi base from load");
        s = '{ld(9,0), addi(9,2)};
        run_seg(s, 0, "R3 second source only no stall");
        s = '{ld(0,3), rr(3,0,0)};
        run_seg(s, 0, "R6 load to register 0");
        s = '{ld(11,0), st(11,2)};
        run_seg(s, 1, "R2 store data after load");
        s = '{ld(12,0), jmp({5'd12, 5'd12, 16'd0})};
        run_seg(s, 0, "R2 jump excluded");
        s = '{ld(13,0), rr(14,2,3), beq(13,1)};
        run_seg(s, 1, "R4 load two ahead of branch");
        s = '{rr(0,1,2), beq(0,0)};
        run_seg(s, 0, "R6 write to register 0 then branch");
        s = '{st(5,6), beq(5,6), jmp(26'h0), beq(5,6)};
        run_seg(s, 0, "R6 store and jump carry zero dest");
        s = '{rr(7,1,2), beq(1,7)};
        run_seg(s, 1, "R5 alu then branch one stall");
        s = '{ld(15,1), rr(16,15,15)};
        run_seg(s, 1, "R11 load then alu one stall");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule